// File: doc/BRIEF.md
# 64-bit Compare Timer

A global 64-bit counter that counts up by one every clock while its run bit is set, paired with one 64-bit comparator that raises a level interrupt. Software reaches the block through a plain 32-bit register port: a write strobe, a word address and write data, with read data returned combinationally for the addressed word. The counter and the compare value are each split into a low and a high 32-bit word, and software may load either word of either value at any time.

When the comparator is enabled, a match is a full 64-bit equality between the counter and the compare value, tested on every clock. A match sets a sticky pending flag. In auto-increment mode the compare value also moves forward by a programmed 32-bit step on every match, so the interrupt repeats with a fixed period and no software reload. The interrupt pin is the pending flag gated by an enable bit, and software acknowledges it by writing a one to the status word. To get a consistent 64-bit snapshot while the counter runs, software reads the high word, then the low word, then the high word again, and repeats if the two high values differ.

Top module: `wide_timer`

## Requirements
- R1: After reset, every register reads zero (control, both counter words, both compare words, step, interrupt enable, status) and `irq` is low.
- R2: A write to word address 1 replaces the counter's low 32 bits and a write to address 2 its high 32 bits; the other half keeps its value, and reads of addresses 1 and 2 return the current counter halves.
- R3: The counter adds one per clock, carrying from the low into the high word and wrapping modulo 2^64, exactly while control bit 0 (address 0) is 1; with that bit 0 it holds. A counter word write in the same cycle wins over the increment.
- R4: Word addresses 3 and 4 hold the low and high halves of the compare value; each reads back what was last written or what auto-increment produced.
- R5: While control bit 1 is 1, a cycle in which the counter equals the compare value in all 64 bits sets the pending flag (status address 7, bit 0) at the next clock edge; while control bit 1 is 0, no counter value sets it.
- R6: With control bits 1 and 2 both 1, each match adds the step value (address 5, zero-extended) to the compare value at the next clock edge, modulo 2^64; a compare word write in that cycle wins.
- R7: `irq` is 1 exactly when the pending flag and interrupt enable (address 6, bit 0) are both 1.
- R8: Writing 1 to status bit 0 clears the pending flag; writing 0 leaves it unchanged; a match in the same cycle as the clearing write keeps it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Word address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data of the addressed word |
| irq | output | 1 | Comparator interrupt |

## Verification
The bench builds the block with its default parameters, a 32-bit register word and a 64-bit counter, so both the word split and the carry chain are the real ones. Because any word can be preloaded, values next to the low-word boundary and next to 2^64 are reached in a few cycles, which brings the low-to-high carry, the full counter wrap and the wrap of the auto-incremented compare value within a short run. Match timing is checked to the exact edge, including a clearing write that collides with a fresh match.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Control word layout, bit 0 upward: run, cmp_en, auto_inc
  typedef struct packed {
    logic auto_inc;
    logic cmp_en;
    logic run;
  } wt_ctrl_t;

  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_CNT_BASE = 1;

endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned NWORDS = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NWORDS-1:0] word_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = run ? bump(cnt) : cnt;
    for (int w = 0; w < NWORDS; w++) begin
      if (word_wr[w]) cnt_nxt[w*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && word_wr == '0) |=> $stable(cnt));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && word_wr == '0) |=> (cnt - $past(cnt)) == CNT_W'(1));

  for (genvar g = 0; g < NWORDS; g++) begin : g_word_chk
    assert_preload_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_wr[g] |=> cnt[g*DATA_W +: DATA_W] == $past(wdata));
  end

endmodule

// File: rtl/wt_compare.sv
module wt_compare #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned NWORDS = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic              auto_inc,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] step,
  input  logic [NWORDS-1:0] word_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp,
  output logic              match
);

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] v,
                                               input logic [DATA_W-1:0] s);
    return v + CNT_W'(s);
  endfunction

  logic [CNT_W-1:0] cmp_nxt;

  assign match = cmp_en && (cnt == cmp);

  always_comb begin
    cmp_nxt = (match && auto_inc) ? advance(cmp, step) : cmp;
    for (int w = 0; w < NWORDS; w++) begin
      if (word_wr[w]) cmp_nxt[w*DATA_W +: DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp <= '0;
    else        cmp <= cmp_nxt;
  end

  assert_autoinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_inc && word_wr == '0) |=> (cmp - $past(cmp)) == CNT_W'($past(step)));

  assert_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && word_wr == '0) |=> $stable(cmp));

  for (genvar g = 0; g < NWORDS; g++) begin : g_word_chk
    assert_cmp_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      word_wr[g] |=> cmp[g*DATA_W +: DATA_W] == $past(wdata));
  end

endmodule

// File: rtl/wt_irq.sv
module wt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  input  logic irq_en,
  output logic pend,
  output logic irq
);

  logic pend_nxt;

  always_comb begin
    pend_nxt = pend;
    if (clr)   pend_nxt = 1'b0;
    if (match) pend_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_nxt;
  end

  assign irq = pend & irq_en;

  assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !pend);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

endmodule

// File: rtl/wide_timer.sv
module wide_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import wt_pkg::*;

  localparam int unsigned NWORDS     = CNT_W / DATA_W;
  localparam int unsigned A_CMP_BASE = A_CNT_BASE + NWORDS;
  localparam int unsigned A_STEP     = A_CMP_BASE + NWORDS;
  localparam int unsigned A_IRQ_EN   = A_STEP + 1;
  localparam int unsigned A_STATUS   = A_IRQ_EN + 1;
  localparam int unsigned CTRL_W     = $bits(wt_ctrl_t);

  wt_ctrl_t          ctrl;
  logic [DATA_W-1:0] step;
  logic              irq_en;
  logic [NWORDS-1:0] cnt_wr, cmp_wr;
  logic [CNT_W-1:0]  cnt, cmp;
  logic              match, pend, clr;

  for (genvar g = 0; g < NWORDS; g++) begin : g_dec
    assign cnt_wr[g] = reg_wr && (reg_addr == ADDR_W'(A_CNT_BASE + g));
    assign cmp_wr[g] = reg_wr && (reg_addr == ADDR_W'(A_CMP_BASE + g));
  end

  assign clr = reg_wr && (reg_addr == ADDR_W'(A_STATUS)) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      step   <= '0;
      irq_en <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(A_CTRL))   ctrl   <= wt_ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_addr == ADDR_W'(A_STEP))   step   <= reg_wdata;
      if (reg_addr == ADDR_W'(A_IRQ_EN)) irq_en <= reg_wdata[0];
    end
  end

  wt_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NWORDS(NWORDS)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.run),
    .word_wr (cnt_wr),
    .wdata   (reg_wdata),
    .cnt     (cnt)
  );

  wt_compare #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NWORDS(NWORDS)) u_compare (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_en   (ctrl.cmp_en),
    .auto_inc (ctrl.auto_inc),
    .cnt      (cnt),
    .step     (step),
    .word_wr  (cmp_wr),
    .wdata    (reg_wdata),
    .cmp      (cmp),
    .match    (match)
  );

  wt_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .match  (match),
    .clr    (clr),
    .irq_en (irq_en),
    .pend   (pend),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL))   reg_rdata = DATA_W'(ctrl);
    if (reg_addr == ADDR_W'(A_STEP))   reg_rdata = step;
    if (reg_addr == ADDR_W'(A_IRQ_EN)) reg_rdata = DATA_W'(irq_en);
    if (reg_addr == ADDR_W'(A_STATUS)) reg_rdata = DATA_W'(pend);
    for (int w = 0; w < NWORDS; w++) begin
      if (reg_addr == ADDR_W'(A_CNT_BASE + w)) reg_rdata = cnt[w*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(A_CMP_BASE + w)) reg_rdata = cmp[w*DATA_W +: DATA_W];
    end
  end

  assert_no_match_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.cmp_en |-> !match);

endmodule

// File: tb/test_wide_timer.sv
module test_wide_timer;
  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 0, A_CLO = 1, A_CHI = 2, A_MLO = 3, A_MHI = 4;
  localparam int A_STEP = 5, A_IEN = 6, A_STAT = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_timer i_wide_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr  = 3'(a);
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 3'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic rd64(input int base, output logic [63:0] v);
    logic [31:0] h1, lo, h2;
    rd(base + 1, h1);
    rd(base, lo);
    rd(base + 1, h2);
    if (h1 != h2) rd(base, lo);
    v = {h2, lo};
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stat(output logic p);
    logic [31:0] d;
    rd(A_STAT, d);
    p = d[0];
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      check("R1 reg after reset", 64'(d), 64'h0);
    end
    check("R1 irq after reset", 64'(irq), 64'h0);
  endtask

  task automatic t_preload;
    logic [63:0] v;
    wr(A_CLO, 32'h89AB_CDEF);
    wr(A_CHI, 32'h0123_4567);
    rd64(A_CLO, v);
    check("R2 preload both words", v, 64'h0123_4567_89AB_CDEF);
    cycles(5);
    rd64(A_CLO, v);
    check("R3 hold while stopped", v, 64'h0123_4567_89AB_CDEF);
    wr(A_CLO, 32'h11);
    rd64(A_CLO, v);
    check("R2 low write keeps high", v, 64'h0123_4567_0000_0011);
  endtask

  task automatic t_count;
    logic [63:0] v;
    wr(A_CLO, 32'hFFFF_FFFE);
    wr(A_CHI, 32'h0);
    wr(A_CTRL, 32'h1);
    rd64(A_CLO, v);
    check("R3 value at start", v, 64'h0000_0000_FFFF_FFFE);
    cycles(3);
    rd64(A_CLO, v);
    check("R3 carry into high word", v, 64'h0000_0001_0000_0001);
    wr(A_CTRL, 32'h0);
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CHI, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    cycles(2);
    rd64(A_CLO, v);
    check("R3 wrap modulo 2^64", v, 64'h1);
    wr(A_CLO, 32'h100);
    rd64(A_CLO, v);
    check("R3 write wins over increment", v, 64'h100);
    cycles(1);
    rd64(A_CLO, v);
    check("R3 counting resumes after write", v, 64'h101);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_match;
    logic [63:0] v;
    logic p;
    wr(A_CLO, 0);
    wr(A_CHI, 0);
    wr(A_MLO, 32'd10);
    wr(A_MHI, 32'h0);
    wr(A_STAT, 1);
    rd64(A_MLO, v);
    check("R4 compare readback", v, 64'd10);
    wr(A_CTRL, 32'h3);
    cycles(10);
    stat(p);
    check("R5 no pending before match edge", 64'(p), 0);
    cycles(1);
    stat(p);
    check("R5 pending one edge after match", 64'(p), 1);
    check("R7 irq low while enable is 0", 64'(irq), 0);
    wr(A_IEN, 1);
    check("R7 irq high with enable", 64'(irq), 1);
  endtask

  task automatic t_clear;
    logic p;
    wr(A_STAT, 0);
    stat(p);
    check("R8 writing 0 keeps pending", 64'(p), 1);
    wr(A_STAT, 1);
    stat(p);
    check("R8 writing 1 clears pending", 64'(p), 0);
    check("R7 irq low after clear", 64'(irq), 0);
    cycles(5);
    stat(p);
    check("R5 no re-match once passed", 64'(p), 0);
  endtask

  task automatic t_disabled;
    logic [63:0] v;
    logic p;
    wr(A_CTRL, 0);
    wr(A_CLO, 0);
    wr(A_MLO, 32'd4);
    wr(A_STAT, 1);
    wr(A_CTRL, 32'h1);
    cycles(8);
    stat(p);
    check("R5 compare disabled sets nothing", 64'(p), 0);
    check("R7 irq low with nothing pending", 64'(irq), 0);
    rd64(A_CLO, v);
    check("R3 counter ran past compare", v, 64'd8);
  endtask

  task automatic t_auto;
    logic [63:0] v;
    logic p;
    wr(A_CTRL, 0);
    wr(A_CLO, 0);
    wr(A_CHI, 0);
    wr(A_MLO, 32'd5);
    wr(A_MHI, 0);
    wr(A_STEP, 32'd4);
    wr(A_STAT, 1);
    wr(A_CTRL, 32'h7);
    cycles(12);
    // matches at 5 and 9 -> compare now 13, counter 12
    rd64(A_MLO, v);
    check("R6 compare advanced twice", v, 64'd13);
    stat(p);
    check("R6 periodic match pending", 64'(p), 1);
    wr(A_CTRL, 0);
    wr(A_CLO, 32'hFFFF_FFFC);
    wr(A_CHI, 32'hFFFF_FFFF);
    wr(A_MLO, 32'hFFFF_FFFE);
    wr(A_MHI, 32'hFFFF_FFFF);
    wr(A_STAT, 1);
    wr(A_CTRL, 32'h7);
    cycles(4);
    rd64(A_MLO, v);
    check("R6 compare wraps modulo 2^64", v, 64'd2);
    cycles(3);
    rd64(A_MLO, v);
    check("R6 match after counter wrap", v, 64'd6);
    rd64(A_CLO, v);
    check("R3 counter after wrap", v, 64'd3);
  endtask

  task automatic t_collide;
    logic p;
    wr(A_CTRL, 0);
    wr(A_CLO, 0);
    wr(A_CHI, 0);
    wr(A_MLO, 32'd3);
    wr(A_MHI, 0);
    wr(A_STAT, 1);
    wr(A_CTRL, 32'h3);
    cycles(3);
    wr(A_STAT, 1);
    stat(p);
    check("R8 match beats clear in same cycle", 64'(p), 1);
    wr(A_STAT, 1);
    stat(p);
    check("R8 later clear works", 64'(p), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset;
    t_preload;
    t_count;
    t_match;
    t_clear;
    t_disabled;
    t_auto;
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule